// File: doc/BRIEF.md
# Multiplexed Bus Byte-Lane Bridge

This bridge sits between a 16-bit master bus that carries address and data on the same pins, in two phases, and a word-wide SRAM made of two byte-wide halves. During the address phase it records the full byte address from the shared pins. In the data phase that follows, the same pins carry data, and the recorded address stays fixed. The bridge drives the SRAM with a word address, which is master address bits 15 down to 1.

In the data phase the bridge classifies the cycle from three inputs: the active-low low-byte strobe, the recorded address bit 0 and the read/write line. It then produces one write enable per byte half and routes the byte lanes. The even (high) byte lives in SRAM bits 15:8 and the odd (low) byte in bits 7:0. An odd-address 16-bit access uses both halves with the two data bytes exchanged.

On reads the bridge always returns both bytes, and the master drops the byte it does not need. When chip select is inactive, the bridge releases the bus and no write enable is active. A write enable depends only on chip select and the data phase, never on an edge of the read/write line. This matters because that line can stay low across back-to-back writes. The bridge also reports a code naming the cycle type.

Top module: `mux_byte_bridge`

## Requirements
- R1: On every clock edge where `addr_phase_i` is 1, the bridge records `ad_i`. `mem_addr_o` equals bits 15:1 of the last recorded value. While `addr_phase_i` stays 0, `mem_addr_o` does not change, whatever `ad_i` carries.
- R2: In the data phase (`addr_phase_i`=0, `cs_ni`=0), `acc_type_o` decodes {`strb_lo_ni`, recorded bit 0, `rw_i`} as follows:
  - 101 gives 1, an even byte read.
  - 011 gives 2, an odd byte read.
  - 100 gives 3, an even byte write.
  - 010 gives 4, an odd byte write.
  - 001 gives 5, a word read.
  - 000 gives 6, a word write.
  - 111 gives 7, a swapped word read.
  - 110 gives 8, a swapped word write.
- R3: A write cycle enables SRAM halves as follows. `mem_we_hi_o` (bits 15:8) is 1 for codes 3, 6 and 8. `mem_we_lo_o` (bits 7:0) is 1 for codes 4, 6 and 8. Neither enable is ever 1 on a read.
- R4: On writes, `mem_wdata_o` equals `ad_i` for codes 3, 4 and 6. For code 8 the two bytes are exchanged: `mem_wdata_o[15:8]`=`ad_i[7:0]` and `mem_wdata_o[7:0]`=`ad_i[15:8]`.
- R5: On every data-phase read, `mem_oe_o` and `ad_oe_o` are 1. `ad_o` carries both bytes of `mem_rdata_i`, with the two bytes exchanged for code 7 and in place otherwise.
- R6: While `cs_ni` is 1, the following hold even if `rw_i` stays 0 between cycles:
  - both write enables, `mem_oe_o` and `ad_oe_o` are 0;
  - `acc_type_o` is 0.
- R7: While `addr_phase_i` is 1, the following hold:
  - both write enables, `mem_oe_o` and `ad_oe_o` are 0;
  - `acc_type_o` is 0.
- R8: After reset, `mem_addr_o` is 0. With chip select inactive, all enables and `acc_type_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_phase_i | input | 1 | 1 during the address phase, 0 during the data phase |
| cs_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 read, 0 write |
| strb_lo_ni | input | 1 | Low-byte strobe, active low |
| ad_i | input | 16 | Multiplexed address/data from the master |
| ad_o | output | 16 | Read data toward the master |
| ad_oe_o | output | 1 | Drive enable for ad_o; 0 means released |
| mem_addr_o | output | 15 | SRAM word address |
| mem_we_hi_o | output | 1 | Write enable, even byte half (bits 15:8) |
| mem_we_lo_o | output | 1 | Write enable, odd byte half (bits 7:0) |
| mem_oe_o | output | 1 | SRAM output enable |
| mem_wdata_o | output | 16 | SRAM write data |
| mem_rdata_i | input | 16 | SRAM read data |
| acc_type_o | output | 4 | Cycle type code, 0 when idle |

## Verification
The bench walks all eight strobe/bit-0/direction combinations on even and odd addresses, with distinct byte values in each lane.

- A decoder that mixed up the two strobe roles would enable the wrong half. Checking both enables on every cycle shows that.
- A router that missed the odd word case would write or return bytes in place. The swapped expectations for codes 7 and 8 catch it.

Back-to-back writes are driven with the read/write line held low and chip select pulsed high between them. A bridge that waited for a read/write edge would miss the second write. A bridge that ignored chip select would write while deselected.

Data-phase cycles also put address-like values on the shared pins. This exposes a capture that stays open after the address phase, because the word address would follow the data.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [3:0] {
    ACC_IDLE     = 4'd0,
    ACC_RD_EVEN8 = 4'd1,
    ACC_RD_ODD8  = 4'd2,
    ACC_WR_EVEN8 = 4'd3,
    ACC_WR_ODD8  = 4'd4,
    ACC_RD_WORD  = 4'd5,
    ACC_WR_WORD  = 4'd6,
    ACC_RD_SWAP  = 4'd7,
    ACC_WR_SWAP  = 4'd8
  } acc_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_HI   = 1;
  localparam int unsigned LANE_LO   = 0;
endpackage

// File: rtl/mbb_addr_hold.sv
module mbb_addr_hold #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [AW-1:0] bus_i,
  output logic [AW-1:0] addr_o
);
  // open while the address phase lasts, frozen once the data phase begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_o <= '0;
    else if (capture_i) addr_o <= bus_i;
  end
endmodule

// File: rtl/mbb_cycle_decode.sv
module mbb_cycle_decode
  import mbb_pkg::*;
(
  input  logic                 active_i,
  input  logic                 strb_lo_ni,
  input  logic                 a0_i,
  input  logic                 rw_i,
  output acc_e                 acc_o,
  output logic [NUM_LANES-1:0] lane_we_o,
  output logic                 rd_o,
  output logic                 swap_o
);
  acc_e                 kind;
  logic [NUM_LANES-1:0] lanes;

  always_comb begin
    kind  = ACC_IDLE;
    lanes = '0;
    unique case ({strb_lo_ni, a0_i, rw_i})
      3'b101: begin kind = ACC_RD_EVEN8; lanes = 2'b10; end
      3'b011: begin kind = ACC_RD_ODD8;  lanes = 2'b01; end
      3'b100: begin kind = ACC_WR_EVEN8; lanes = 2'b10; end
      3'b010: begin kind = ACC_WR_ODD8;  lanes = 2'b01; end
      3'b001: begin kind = ACC_RD_WORD;  lanes = 2'b11; end
      3'b000: begin kind = ACC_WR_WORD;  lanes = 2'b11; end
      3'b111: begin kind = ACC_RD_SWAP;  lanes = 2'b11; end
      3'b110: begin kind = ACC_WR_SWAP;  lanes = 2'b11; end
      default: begin kind = ACC_IDLE;    lanes = 2'b00; end
    endcase
  end

  // qualified by select and phase only, never by a direction edge
  assign acc_o     = active_i ? kind : ACC_IDLE;
  assign lane_we_o = (active_i && !rw_i) ? lanes : '0;
  assign rd_o      = active_i && rw_i;
  assign swap_o    = strb_lo_ni && a0_i;
endmodule

// File: rtl/mbb_lane_xbar.sv
module mbb_lane_xbar #(
  parameter int unsigned LW    = 8,
  parameter int unsigned LANES = 2
) (
  input  logic                swap_i,
  input  logic [LANES*LW-1:0] bus_wdata_i,
  input  logic [LANES*LW-1:0] mem_rdata_i,
  output logic [LANES*LW-1:0] mem_wdata_o,
  output logic [LANES*LW-1:0] bus_rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned MIRROR = LANES - 1 - g;
    assign mem_wdata_o[g*LW +: LW] = swap_i ? bus_wdata_i[MIRROR*LW +: LW]
                                            : bus_wdata_i[g*LW +: LW];
    assign bus_rdata_o[g*LW +: LW] = swap_i ? mem_rdata_i[MIRROR*LW +: LW]
                                            : mem_rdata_i[g*LW +: LW];
  end
endmodule

// File: rtl/mux_byte_bridge.sv
module mux_byte_bridge
  import mbb_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = NUM_LANES * LANE_W,
  localparam int unsigned MAW   = DW - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           addr_phase_i,
  input  logic           cs_ni,
  input  logic           rw_i,
  input  logic           strb_lo_ni,
  input  logic [DW-1:0]  ad_i,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic           mem_we_hi_o,
  output logic           mem_we_lo_o,
  output logic           mem_oe_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [3:0]     acc_type_o
);
  logic [DW-1:0]        addr_q;
  logic                 active;
  logic                 rd;
  logic                 swap;
  logic [NUM_LANES-1:0] lane_we;
  acc_e                 acc;

  assign active = !addr_phase_i && !cs_ni;

  mbb_addr_hold #(.AW(DW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (addr_phase_i),
    .bus_i     (ad_i),
    .addr_o    (addr_q)
  );

  mbb_cycle_decode u_dec (
    .active_i   (active),
    .strb_lo_ni (strb_lo_ni),
    .a0_i       (addr_q[0]),
    .rw_i       (rw_i),
    .acc_o      (acc),
    .lane_we_o  (lane_we),
    .rd_o       (rd),
    .swap_o     (swap)
  );

  mbb_lane_xbar #(.LW(LANE_W), .LANES(NUM_LANES)) u_xbar (
    .swap_i      (swap),
    .bus_wdata_i (ad_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_wdata_o (mem_wdata_o),
    .bus_rdata_o (ad_o)
  );

  assign mem_addr_o  = addr_q[DW-1:1];
  assign mem_we_hi_o = lane_we[LANE_HI];
  assign mem_we_lo_o = lane_we[LANE_LO];
  assign mem_oe_o    = rd;
  assign ad_oe_o     = rd;
  assign acc_type_o  = acc;
endmodule

// File: rtl/mbb_chk.sv
module mbb_chk #(
  parameter int unsigned MAW = 15
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           addr_phase_i,
  input logic           cs_ni,
  input logic           rw_i,
  input logic [MAW-1:0] mem_addr_o,
  input logic           mem_we_hi_o,
  input logic           mem_we_lo_o,
  input logic           mem_oe_o,
  input logic           ad_oe_o,
  input logic [3:0]     acc_type_o
);
  // R1
  addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(addr_phase_i) |-> $stable(mem_addr_o));
  // R3
  we_only_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_hi_o || mem_we_lo_o) |-> !rw_i);
  // R5
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (mem_oe_o && rw_i && !mem_we_hi_o && !mem_we_lo_o));
  // R6
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!mem_we_hi_o && !mem_we_lo_o && !ad_oe_o && !mem_oe_o && acc_type_o == 4'd0));
  // R7
  addr_phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_phase_i |-> (!mem_we_hi_o && !mem_we_lo_o && !ad_oe_o && acc_type_o == 4'd0));
  // R2
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_type_o <= 4'd8);
endmodule

bind mux_byte_bridge mbb_chk #(.MAW(MAW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_phase_i (addr_phase_i),
  .cs_ni        (cs_ni),
  .rw_i         (rw_i),
  .mem_addr_o   (mem_addr_o),
  .mem_we_hi_o  (mem_we_hi_o),
  .mem_we_lo_o  (mem_we_lo_o),
  .mem_oe_o     (mem_oe_o),
  .ad_oe_o      (ad_oe_o),
  .acc_type_o   (acc_type_o)
);

// File: tb/sim_mux_byte_bridge.sv
`timescale 1ns/1ps
module sim_mux_byte_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_i = 1'b0, cs_n = 1'b1, rw = 1'b1, strb_n = 1'b1;
  logic [15:0] ad_in = '0, rdata = '0;
  logic [15:0] ad_out, wdata;
  logic        ad_oe, we_hi, we_lo, oe;
  logic [14:0] maddr;
  logic [3:0]  acc;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model_addr = '0;

  always #2 clk = ~clk;

  mux_byte_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_phase_i(as_i), .cs_ni(cs_n), .rw_i(rw),
    .strb_lo_ni(strb_n), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .mem_addr_o(maddr), .mem_we_hi_o(we_hi), .mem_we_lo_o(we_lo), .mem_oe_o(oe),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .acc_type_o(acc)
  );

  // behavioural reference: recorded address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_addr <= '0;
    else if (as_i) model_addr <= ad_in;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int code, ehi, elo, swp;
      bit live;
      string rq;
      live = !as_i && !cs_n;
      code = 0; ehi = 0; elo = 0; swp = 0;
      if (live) begin
        case ({strb_n, model_addr[0], rw})
          3'b101: code = 1;
          3'b011: code = 2;
          3'b100: begin code = 3; ehi = 1; end
          3'b010: begin code = 4; elo = 1; end
          3'b001: code = 5;
          3'b000: begin code = 6; ehi = 1; elo = 1; end
          3'b111: begin code = 7; swp = 1; end
          default: begin code = 8; ehi = 1; elo = 1; swp = 1; end
        endcase
      end
      rq = !rst_n ? "R8" : cs_n ? "R6" : as_i ? "R7" : "R3";
      chk(rst_n ? "R1" : "R8", "mem_addr", maddr, model_addr[15:1]);
      chk(live ? "R2" : rq, "acc_type", acc, code);
      chk(rq, "we_hi", we_hi, ehi);
      chk(rq, "we_lo", we_lo, elo);
      chk(live ? "R5" : rq, "ad_oe", ad_oe, live && rw);
      chk(live ? "R5" : rq, "mem_oe", oe, live && rw);
      if (live && !rw)
        chk("R4", "wdata", wdata, swp ? {ad_in[7:0], ad_in[15:8]} : ad_in);
      if (live && rw)
        chk("R5", "ad_o", ad_out, swp ? {rdata[7:0], rdata[15:8]} : rdata);
    end
  end

  task automatic bus_cycle(logic [15:0] addr, logic sn, logic r,
                           logic [15:0] dat, logic [15:0] rd, logic csn);
    @(posedge clk); #1;
    as_i = 1'b1; cs_n = csn; ad_in = addr; rw = r; strb_n = sn;
    @(posedge clk); #1;
    as_i = 1'b0; ad_in = dat; rdata = rd;   // data may look like an address (R1)
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // all decode combinations, even and odd addresses (R2..R5)
    bus_cycle(16'h1234, 1, 1, 16'hFFFF, 16'hA1B2, 0);  // even byte read
    bus_cycle(16'h2345, 0, 1, 16'h0000, 16'hC3D4, 0);  // odd byte read
    bus_cycle(16'h4A6C, 1, 0, 16'h5A00, 16'h0000, 0);  // even byte write
    bus_cycle(16'h4A6D, 0, 0, 16'h00A5, 16'h0000, 0);  // odd byte write
    bus_cycle(16'h8000, 0, 1, 16'h7777, 16'h1122, 0);  // word read
    bus_cycle(16'h0FFE, 0, 0, 16'hBEEF, 16'h0000, 0);  // word write
    bus_cycle(16'hFFFF, 1, 1, 16'h0001, 16'h3344, 0);  // swapped read
    bus_cycle(16'h7001, 1, 0, 16'hCAFE, 16'h0000, 0);  // swapped write
    // back-to-back writes, rw held low, select pulsed (R6)
    bus_cycle(16'h0100, 0, 0, 16'h1111, 16'h0, 0);
    bus_cycle(16'h0102, 0, 0, 16'h2222, 16'h0, 1);
    bus_cycle(16'h0104, 0, 0, 16'h3333, 16'h0, 0);
    bus_cycle(16'h0107, 0, 0, 16'h0044, 16'h0, 0);
    // deselected read must not drive (R6)
    bus_cycle(16'h5555, 0, 1, 16'h0, 16'h9999, 1);
    for (int i = 0; i < 8; i++)
      bus_cycle(16'h1000 + 16'(i * 257), logic'(i[0]), logic'(i[1]), 16'hF00F ^ 16'(i), 16'h0FF0 + 16'(i), 0);
    @(posedge clk); #1 cs_n = 1'b1; as_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #0.5;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule